// File: doc/BRIEF.md
# Self-Routing Omega Switch Fabric

This block connects eight requesters, for example processors, to eight numbered targets such as memory banks. It uses three columns of two-by-two exchange elements. A perfect-shuffle permutation sits in front of every column. Each requester offers a valid flag, a 3-bit target number and a data word. The request steers itself: each column looks at one bit of the target number, starting from the most significant bit, and sends the request to the upper or lower output of its element.

When two live requests in one element want the same output, the request on the lower-numbered line (input A) proceeds. The other request is dropped for that cycle, even if the two would have ended at different targets. The whole fabric is combinational from the inputs to one register stage.

In the cycle after sampling, each output port shows whether it carries a request, which requester sent it, and the data word. Two per-requester masks report which requests were granted and which were blocked. There is no back-pressure. Outputs carry no ready and must be taken in the cycle they appear. Inputs carry no ready either: a blocked requester learns its fate from the blocked mask and may offer the request again later.

Top module: `omega_fabric`

## Requirements
- R1: While reset is asserted (rst_n low, asynchronous), and in the first cycle after it, out_valid, grant and blocked are all zero.
- R2: A valid request with no competitor appears on the output port whose index equals its 3-bit target number, one clock edge after it is sampled. out_src carries the index of the requester.
- R3: The data word of a delivered request reaches out_data unchanged.
- R4: Before each of the three columns, line i moves to line ((i<<1)|(i>>2))&7. Element j of a column takes lines 2j (input A) and 2j+1 (input B) and drives line 2j (output 0) and line 2j+1 (output 1). Column k routes on target bit 2-k: a 0 goes to output 0 and a 1 goes to output 1.
- R5: When inputs A and B of one element are both valid and select the same output, A wins and B is dropped, even if their target numbers differ. For example, requester 0 to target 0 against requester 4 to target 1 delivers only requester 0.
- R6: In the cycle the outputs appear, grant[i] is 1 exactly when requester i's request is on some output. blocked[i] is 1 exactly when requester i was valid and not delivered. Idle requesters show neither.
- R7: Every cyclic shift pattern (requester i to target (i+c)&7) delivers all eight requests with no blocking.
- R8: An invalid input occupies no element output. A request paired with an idle line is never blocked, whatever the idle line's target number.
- R9: Outputs hold nothing over. A cycle with no valid inputs yields all outputs invalid on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 8 | Per-requester request flag |
| in_dest | input | 8x3 | Per-requester target number |
| in_data | input | 8x8 | Per-requester data word |
| out_valid | output | 8 | Per-output delivery flag |
| out_src | output | 8x3 | Requester index delivered on each output |
| out_data | output | 8x8 | Data word delivered on each output |
| grant | output | 8 | Requester delivered last cycle |
| blocked | output | 8 | Requester valid last cycle but dropped |

## Verification
The fabric is tried with several kinds of pattern:
- Lone requests confirm where each target number lands and that the data word arrives intact.
- Cyclic shifts and the identity pattern are known to pass without contention, so they expose any stray conflict or wrong wiring.
- Bit-reversal, all-to-one and pairs meeting in the first column force conflicts. They tell apart a correct A-wins rule from a B-wins rule or from a rule keyed on the final target.
- Idle lines that carry clashing target numbers show whether an invalid input wrongly takes an element output.

All patterns are checked against a reference model of the shuffle and exchange steps.

// File: rtl/omega_pkg.sv
package omega_pkg;
  // perfect shuffle: rotate the line number left by one within s bits
  function automatic int unsigned shuffle_pos(int unsigned line, int unsigned s);
    return ((line << 1) | (line >> (s - 1))) & ((1 << s) - 1);
  endfunction
endpackage

// File: rtl/omega_switch.sv
module omega_switch #(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SEL    = 2
) (
  input  logic              a_vld,
  input  logic [TAG_W-1:0]  a_dst,
  input  logic [TAG_W-1:0]  a_src,
  input  logic [DATA_W-1:0] a_dat,
  input  logic              b_vld,
  input  logic [TAG_W-1:0]  b_dst,
  input  logic [TAG_W-1:0]  b_src,
  input  logic [DATA_W-1:0] b_dat,
  output logic              u_vld,
  output logic [TAG_W-1:0]  u_dst,
  output logic [TAG_W-1:0]  u_src,
  output logic [DATA_W-1:0] u_dat,
  output logic              l_vld,
  output logic [TAG_W-1:0]  l_dst,
  output logic [TAG_W-1:0]  l_src,
  output logic [DATA_W-1:0] l_dat
);
  logic a_bit, b_bit, b_ok;

  assign a_bit = a_dst[SEL];
  assign b_bit = b_dst[SEL];
  // B survives unless a live A claims the same output
  assign b_ok  = b_vld && !(a_vld && (a_bit == b_bit));

  always_comb begin
    u_vld = 1'b0; u_dst = '0; u_src = '0; u_dat = '0;
    l_vld = 1'b0; l_dst = '0; l_src = '0; l_dat = '0;
    if (a_vld && !a_bit) begin
      u_vld = 1'b1; u_dst = a_dst; u_src = a_src; u_dat = a_dat;
    end else if (b_ok && !b_bit) begin
      u_vld = 1'b1; u_dst = b_dst; u_src = b_src; u_dat = b_dat;
    end
    if (a_vld && a_bit) begin
      l_vld = 1'b1; l_dst = a_dst; l_src = a_src; l_dat = a_dat;
    end else if (b_ok && b_bit) begin
      l_vld = 1'b1; l_dst = b_dst; l_src = b_src; l_dat = b_dat;
    end
  end
endmodule

// File: rtl/omega_stage.sv
module omega_stage #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned COL    = 0,
  localparam int unsigned N     = 1 << STAGES
) (
  input  logic [N-1:0]             i_vld,
  input  logic [N-1:0][STAGES-1:0] i_dst,
  input  logic [N-1:0][STAGES-1:0] i_src,
  input  logic [N-1:0][DATA_W-1:0] i_dat,
  output logic [N-1:0]             o_vld,
  output logic [N-1:0][STAGES-1:0] o_dst,
  output logic [N-1:0][STAGES-1:0] o_src,
  output logic [N-1:0][DATA_W-1:0] o_dat
);
  import omega_pkg::*;

  logic [N-1:0]             s_vld;
  logic [N-1:0][STAGES-1:0] s_dst;
  logic [N-1:0][STAGES-1:0] s_src;
  logic [N-1:0][DATA_W-1:0] s_dat;

  for (genvar i = 0; i < N; i++) begin : g_shuf
    localparam int unsigned P = shuffle_pos(i, STAGES);
    assign s_vld[P] = i_vld[i];
    assign s_dst[P] = i_dst[i];
    assign s_src[P] = i_src[i];
    assign s_dat[P] = i_dat[i];
  end

  for (genvar j = 0; j < N/2; j++) begin : g_sw
    omega_switch #(
      .TAG_W(STAGES), .DATA_W(DATA_W), .SEL(STAGES-1-COL)
    ) i_sw (
      .a_vld(s_vld[2*j]),   .a_dst(s_dst[2*j]),   .a_src(s_src[2*j]),   .a_dat(s_dat[2*j]),
      .b_vld(s_vld[2*j+1]), .b_dst(s_dst[2*j+1]), .b_src(s_src[2*j+1]), .b_dat(s_dat[2*j+1]),
      .u_vld(o_vld[2*j]),   .u_dst(o_dst[2*j]),   .u_src(o_src[2*j]),   .u_dat(o_dat[2*j]),
      .l_vld(o_vld[2*j+1]), .l_dst(o_dst[2*j+1]), .l_src(o_src[2*j+1]), .l_dat(o_dat[2*j+1])
    );
  end
endmodule

// File: rtl/omega_fabric.sv
module omega_fabric #(
  parameter int unsigned STAGES = 3,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned N     = 1 << STAGES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N-1:0]             in_valid,
  input  logic [N-1:0][STAGES-1:0] in_dest,
  input  logic [N-1:0][DATA_W-1:0] in_data,
  output logic [N-1:0]             out_valid,
  output logic [N-1:0][STAGES-1:0] out_src,
  output logic [N-1:0][DATA_W-1:0] out_data,
  output logic [N-1:0]             grant,
  output logic [N-1:0]             blocked
);
  logic [STAGES:0][N-1:0]             l_vld;
  logic [STAGES:0][N-1:0][STAGES-1:0] l_dst;
  logic [STAGES:0][N-1:0][STAGES-1:0] l_src;
  logic [STAGES:0][N-1:0][DATA_W-1:0] l_dat;
  logic [N-1:0] gnt_d;

  assign l_vld[0] = in_valid;
  assign l_dst[0] = in_dest;
  assign l_dat[0] = in_data;
  for (genvar i = 0; i < N; i++) begin : g_tag
    assign l_src[0][i] = STAGES'(i);
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_col
    omega_stage #(.STAGES(STAGES), .DATA_W(DATA_W), .COL(k)) i_stage (
      .i_vld(l_vld[k]),   .i_dst(l_dst[k]),   .i_src(l_src[k]),   .i_dat(l_dat[k]),
      .o_vld(l_vld[k+1]), .o_dst(l_dst[k+1]), .o_src(l_src[k+1]), .o_dat(l_dat[k+1])
    );
  end

  always_comb begin
    gnt_d = '0;
    for (int o = 0; o < N; o++)
      if (l_vld[STAGES][o]) gnt_d[l_src[STAGES][o]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_src   <= '0;
      out_data  <= '0;
      grant     <= '0;
      blocked   <= '0;
    end else begin
      out_valid <= l_vld[STAGES];
      out_src   <= l_src[STAGES];
      out_data  <= l_dat[STAGES];
      grant     <= gnt_d;
      blocked   <= in_valid & ~gnt_d;
    end
  end

  // checking state: a copy of last cycle's inputs
  logic                     armed;
  logic [N-1:0]             q_vld;
  logic [N-1:0][STAGES-1:0] q_dst;
  logic [N-1:0][DATA_W-1:0] q_dat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; q_vld <= '0; q_dst <= '0; q_dat <= '0;
    end else begin
      armed <= 1'b1; q_vld <= in_valid; q_dst <= in_dest; q_dat <= in_data;
    end
  end

  for (genvar o = 0; o < N; o++) begin : g_chk
    a_r2_lands_on_tag: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid[o]) |-> (q_vld[out_src[o]] && q_dst[out_src[o]] == STAGES'(o)));
    a_r3_data_intact: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && out_valid[o]) |-> (out_data[o] == q_dat[out_src[o]]));
  end

  a_r8_lone_never_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $countones(q_vld) == 1) |-> ($countones(out_valid) == 1 && blocked == '0));
  a_r6_status_partition: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((grant | blocked) == q_vld && $countones(grant) == $countones(out_valid)));
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (out_valid == '0 && grant == '0 && blocked == '0));
endmodule

// File: tb/test_omega_fabric.sv
module test_omega_fabric;
  localparam int N = 8;
  localparam int S = 3;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]        in_valid = '0;
  logic [N-1:0][S-1:0] in_dest = '0;
  logic [N-1:0][W-1:0] in_data = '0;
  logic [N-1:0]        out_valid;
  logic [N-1:0][S-1:0] out_src;
  logic [N-1:0][W-1:0] out_data;
  logic [N-1:0]        grant, blocked;

  int total = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  omega_fabric #(.STAGES(S), .DATA_W(W)) i_omega_fabric (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_src(out_src), .out_data(out_data),
    .grant(grant), .blocked(blocked));

  // {valid mask, dest of requester 7 .. requester 0}
  localparam logic [31:0] VEC [10] = '{
    {8'hFF, 24'o76543210},  // identity
    {8'hFF, 24'o07654321},  // shift by 1
    {8'hFF, 24'o32107654},  // shift by 4
    {8'hFF, 24'o73516240},  // bit reversal
    {8'hFF, 24'o00000000},  // all to one
    {8'h11, 24'o00010000},  // 0->0, 4->1 conflict
    {8'h10, 24'o00010000},  // 4 alone, idle 0 shares dest bit
    {8'h00, 24'o76543210},  // nothing valid
    {8'hA5, 24'o12345670},
    {8'h3C, 24'o55443322}
  };

  logic [N-1:0]        e_vld;
  logic [N-1:0][S-1:0] e_src;
  logic [N-1:0][W-1:0] e_dat;
  logic [N-1:0]        e_gnt;

  task automatic model(input logic [N-1:0] v, input logic [N-1:0][S-1:0] d,
                       input logic [N-1:0][W-1:0] x);
    logic [N-1:0] cv, sv; logic [N-1:0][S-1:0] cd, cs, sd, ss; logic [N-1:0][W-1:0] cx, sx;
    cv = v; cd = d; cx = x;
    for (int i = 0; i < N; i++) cs[i] = S'(i);
    for (int k = 0; k < S; k++) begin
      for (int i = 0; i < N; i++) begin
        int p; p = ((i << 1) | (i >> 2)) & 7;
        sv[p] = cv[i]; sd[p] = cd[i]; ss[p] = cs[i]; sx[p] = cx[i];
      end
      cv = '0; cd = '0; cs = '0; cx = '0;
      for (int j = 0; j < N/2; j++) begin
        for (int side = 0; side < 2; side++) begin
          int ln; int b; ln = 2*j + side;
          if (sv[ln]) begin
            b = sd[ln][2-k];
            if (!cv[2*j+b]) begin
              cv[2*j+b] = 1'b1; cd[2*j+b] = sd[ln]; cs[2*j+b] = ss[ln]; cx[2*j+b] = sx[ln];
            end
          end
        end
      end
    end
    e_vld = cv; e_src = cs; e_dat = cx; e_gnt = '0;
    for (int o = 0; o < N; o++) if (cv[o]) e_gnt[cs[o]] = 1'b1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [N-1:0] v, input logic [N-1:0][S-1:0] d, input int seed);
    logic [N-1:0][W-1:0] x;
    for (int i = 0; i < N; i++) x[i] = W'(i*29 + seed*7 + 3);
    @(negedge clk);
    in_valid = v; in_dest = d; in_data = x;
    model(v, d, x);
    @(negedge clk);
    in_valid = '0;
  endtask

  task automatic check_out(input string req);
    logic [N-1:0][S-1:0] ms; logic [N-1:0][W-1:0] mx;
    for (int o = 0; o < N; o++) begin
      ms[o] = out_valid[o] ? out_src[o] : '0;
      mx[o] = out_valid[o] ? out_data[o] : '0;
      if (!e_vld[o]) begin e_src[o] = '0; e_dat[o] = '0; end
    end
    check(out_valid == e_vld, req, "R2 out_valid", 64'(out_valid), 64'(e_vld));
    check(ms == e_src, req, "R2 out_src", 64'(ms), 64'(e_src));
    check(mx == e_dat, req, "R3 out_data", 64'(mx), 64'(e_dat));
    check(grant == e_gnt, req, "R6 grant", 64'(grant), 64'(e_gnt));
    check(blocked == (in_valid_last & ~e_gnt), req, "R6 blocked",
          64'(blocked), 64'(in_valid_last & ~e_gnt));
  endtask

  logic [N-1:0] in_valid_last;

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    in_valid = '1; in_dest = '0;
    #35;
    check(out_valid == '0 && grant == '0 && blocked == '0, "R1", "reset outputs",
          64'({out_valid, grant, blocked}), 64'(0));
    @(negedge clk); in_valid = '0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == '0 && grant == '0 && blocked == '0, "R1", "first cycle after reset",
          64'({out_valid, grant, blocked}), 64'(0));

    // table walk: R2 R3 R4 R5 R6 R7 R8 R9 against the model
    for (int r = 0; r < 10; r++) begin
      in_valid_last = VEC[r][31:24];
      apply(VEC[r][31:24], VEC[r][23:0], r);
      check_out($sformatf("R4 row%0d", r));
    end

    // R7: all cyclic shifts deliver everything
    for (int c = 0; c < N; c++) begin
      logic [N-1:0][S-1:0] d;
      for (int i = 0; i < N; i++) d[i] = S'(i + c);
      in_valid_last = '1;
      apply('1, d, 20 + c);
      check(grant == '1 && blocked == '0, "R7", $sformatf("shift %0d", c),
            64'({grant, blocked}), 64'({8'hFF, 8'h00}));
    end

    // R5: requester 0 -> target 0 beats requester 4 -> target 1
    in_valid_last = 8'h11;
    apply(8'h11, 24'o00010000, 40);
    check(out_valid == 8'h01 && out_src[0] == 3'd0, "R5", "A wins, different targets",
          64'({out_valid, 5'd0, out_src[0]}), 64'(16'h0100));
    check(blocked == 8'h10 && grant == 8'h01, "R5", "B blocked",
          64'({grant, blocked}), 64'(16'h0110));

    // R8: idle line with clashing target does not block
    in_valid_last = 8'h10;
    apply(8'h10, 24'o00010000, 41);
    check(out_valid == 8'h02 && out_src[1] == 3'd4, "R8", "idle A takes nothing",
          64'({out_valid, 5'd0, out_src[1]}), 64'(16'h0204));

    // R2: each target alone from requester 5
    for (int t = 0; t < N; t++) begin
      logic [N-1:0][S-1:0] d;
      d = '0; d[5] = S'(t);
      in_valid_last = 8'h20;
      apply(8'h20, d, 50 + t);
      check(out_valid == (8'h01 << t) && out_src[t] == 3'd5, "R2", $sformatf("lone to %0d", t),
            64'({out_valid, 5'd0, out_src[t]}), 64'({8'h01 << t, 8'h05}));
    end

    // R9: idle cycle clears outputs
    @(negedge clk);
    check(out_valid == '0 && grant == '0 && blocked == '0, "R9", "no hold-over",
          64'({out_valid, grant, blocked}), 64'(0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule